// File: doc/BRIEF.md
# Single-Entry Posted Store Buffer

This block sits between a processor's load/store unit and a pipelined system bus whose slave can stretch a data phase with wait states. A store costs the core a single cycle. The address phase goes out in the cycle the store is presented. The data phase runs in the following cycle or cycles while the core moves on. The block owns one slot, which is the store's data phase. When the slave holds off that data phase, the store is parked in the slot. Instructions that make no memory access keep retiring. The next load or store is held until the slot drains.

Loads do not bypass a parked store. A load waits until the slot drains, then issues. It keeps the core stalled through its own data phase and retires in the cycle the slave returns ready, so bus order always equals program order. A mode input turns posting off. In that mode a store whose data phase is waited blocks every following instruction, memory or not, until the bus completes it. The core side is a plain request/stall handshake: a request stays on the inputs until a cycle in which the stall output is low. The core never presents a store and a load in the same cycle.

Top module: `wr_post_buf`

## Requirements
- R1: At most one data phase is outstanding. An address phase (`bus_avalid`=1) is issued only when no data phase is pending, or when the pending one completes in that same cycle (`bus_ready`=1).
- R2: A store presented while the bus is idle does not stall. Its address phase (`bus_write`=1, `bus_addr`=store address) appears in the same cycle. Its byte enables appear on `bus_wbe` from the next cycle until its data phase completes.
- R3: A store whose data phase completes without wait states leaves the slot empty. A load or store presented in that completing cycle issues at once, without a stall cycle caused by the store.
- R4: While a store's data phase is waited, a presented load or store keeps `core_stall` high. It issues its address phase in the cycle `bus_ready` returns high.
- R5: With posting enabled (`buf_en`=1), a cycle with no load or store request never stalls, whatever state the slot is in.
- R6: With posting disabled (`buf_en`=0), `core_stall` is high in every cycle in which a store data phase is waited, whatever the core presents.
- R7: For two back-to-back stores where the first has N wait states, the second stalls for exactly N cycles. It issues in the cycle the first drains, and its data phase begins in the next cycle.
- R8: A load stalls in its address cycle and in every wait cycle of its data phase. It retires in the cycle `bus_ready` is high, with `ld_rdata` equal to `bus_rdata` of that cycle.
- R9: Bus transactions appear in program order with the core's addresses. A store's write data stays stable on `bus_wdata` for all of its wait states.
- R10: During a store's data phase, each 8-bit lane k of `bus_wdata` (bits 8k+7..8k) carries the store data when `st_be[k]` was 1 and is zero when it was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_en | input | 1 | 1 = post stores into the slot, 0 = a waited store blocks the core |
| st_req | input | 1 | Store presented this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables, bit k for lane k |
| ld_req | input | 1 | Load presented this cycle |
| ld_addr | input | AW | Load address |
| core_stall | output | 1 | Presented instruction does not retire this cycle |
| ld_rdata | output | DW | Load data, valid when a load retires |
| bus_avalid | output | 1 | Address phase valid |
| bus_write | output | 1 | Address phase is a write |
| bus_addr | output | AW | Address phase address |
| bus_wdata | output | DW | Write data during a store data phase |
| bus_wbe | output | DW/8 | Byte enables during a store data phase |
| bus_rdata | input | DW | Read data from the slave |
| bus_ready | input | 1 | Data phase completes this cycle |

## Verification
The hardest situation to reach is the collision between a parked store and the core's next move. That move can be a non-memory cycle that must slip past, a load that must wait behind the store, or a second store that must issue in exactly the drain cycle. Reaching it takes control of the slave's wait count and of the spacing of core requests at the same time. The bench plays the slave itself and takes each wait count either from a directed queue or from a random draw. It runs hand-timed sequences (stalled store then store, stalled store then idle cycles then load, a waited load alone) in both modes, and then long random mixes in both modes against a cycle-by-cycle reference.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
  // Kind of data phase currently owned by the block
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;
endpackage

// File: rtl/wbuf_issue_ctl.sv
`timescale 1ns/1ps
module wbuf_issue_ctl
  import wbuf_pkg::*;
(
  input  logic   buf_en,
  input  logic   st_req,
  input  logic   ld_req,
  input  phase_e ph_kind,
  input  logic   bus_ready,
  output logic   issue,
  output logic   issue_write,
  output logic   stall
);
  logic phase_busy;
  logic bus_free;
  logic own_load;
  logic ld_done;
  logic write_waiting;

  always_comb begin
    phase_busy    = (ph_kind != PH_IDLE);
    bus_free      = !phase_busy || bus_ready;
    // a pending read can only belong to the load still on the inputs
    own_load      = ld_req && (ph_kind == PH_READ);
    ld_done       = own_load && bus_ready;
    write_waiting = (ph_kind == PH_WRITE) && !bus_ready;

    issue       = (st_req || (ld_req && !own_load)) && bus_free;
    issue_write = st_req;

    if (st_req)      stall = !bus_free;
    else if (ld_req) stall = !ld_done;
    else             stall = !buf_en && write_waiting;
  end
endmodule

// File: rtl/wbuf_phase_reg.sv
`timescale 1ns/1ps
module wbuf_phase_reg
  import wbuf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LANE = 8
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 buf_en,
  input  logic                 issue,
  input  logic                 issue_write,
  input  logic [DW-1:0]        st_data,
  input  logic [DW/LANE-1:0]   st_be,
  input  logic                 bus_ready,
  output phase_e               ph_kind,
  output logic [DW-1:0]        ph_wdata,
  output logic [DW/LANE-1:0]   ph_be,
  output logic                 slot_full
);
  localparam int BW = DW / LANE;

  logic [DW-1:0] masked;

  for (genvar g = 0; g < BW; g++) begin : g_lane
    assign masked[g*LANE +: LANE] = st_be[g] ? st_data[g*LANE +: LANE] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_kind   <= PH_IDLE;
      ph_wdata  <= '0;
      ph_be     <= '0;
      slot_full <= 1'b0;
    end else begin
      if (issue)          ph_kind <= issue_write ? PH_WRITE : PH_READ;
      else if (bus_ready) ph_kind <= PH_IDLE;
      if (issue && issue_write) begin
        ph_wdata <= masked;
        ph_be    <= st_be;
      end
      // a store becomes parked only once the slave has waited its data phase
      slot_full <= (ph_kind == PH_WRITE) && !bus_ready && buf_en;
    end
  end
endmodule

// File: rtl/wr_post_buf.sv
`timescale 1ns/1ps
module wr_post_buf
  import wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_en,
  input  logic              st_req,
  input  logic [AW-1:0]     st_addr,
  input  logic [DW-1:0]     st_data,
  input  logic [DW/8-1:0]   st_be,
  input  logic              ld_req,
  input  logic [AW-1:0]     ld_addr,
  output logic              core_stall,
  output logic [DW-1:0]     ld_rdata,
  output logic              bus_avalid,
  output logic              bus_write,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic [DW/8-1:0]   bus_wbe,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready
);
  localparam int LANE = 8;
  localparam int BW   = DW / LANE;

  phase_e          ph_kind;
  logic            slot_full;
  logic            issue;
  logic            issue_write;
  logic [DW-1:0]   ph_wdata;
  logic [BW-1:0]   ph_be;

  wbuf_issue_ctl u_ctl (
    .buf_en      (buf_en),
    .st_req      (st_req),
    .ld_req      (ld_req),
    .ph_kind     (ph_kind),
    .bus_ready   (bus_ready),
    .issue       (issue),
    .issue_write (issue_write),
    .stall       (core_stall)
  );

  wbuf_phase_reg #(.DW(DW), .LANE(LANE)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .buf_en      (buf_en),
    .issue       (issue),
    .issue_write (issue_write),
    .st_data     (st_data),
    .st_be       (st_be),
    .bus_ready   (bus_ready),
    .ph_kind     (ph_kind),
    .ph_wdata    (ph_wdata),
    .ph_be       (ph_be),
    .slot_full   (slot_full)
  );

  assign bus_avalid = issue;
  assign bus_write  = issue_write;
  assign bus_addr   = st_req ? st_addr : ld_addr;
  assign bus_wdata  = ph_wdata;
  assign bus_wbe    = ph_be;
  assign ld_rdata   = bus_rdata;
endmodule

// File: rtl/wr_post_buf_chk.sv
`timescale 1ns/1ps
module wr_post_buf_chk
  import wbuf_pkg::*;
#(
  parameter int DW = 32
)(
  input logic          clk,
  input logic          rst,
  input logic          buf_en,
  input logic          st_req,
  input logic          ld_req,
  input logic          core_stall,
  input logic          bus_avalid,
  input logic          bus_ready,
  input logic [DW-1:0] bus_wdata,
  input phase_e        ph_kind,
  input logic          slot_full
);
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    bus_avalid |-> (ph_kind == PH_IDLE || bus_ready));  // R1
  AST_IDLE_STORE_FREE: assert property (@(posedge clk) disable iff (rst)
    (st_req && ph_kind == PH_IDLE) |-> (!core_stall && bus_avalid));  // R2
  AST_SLOT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (slot_full && (st_req || ld_req) && !bus_ready) |-> core_stall);  // R4
  AST_NOP_FREE: assert property (@(posedge clk) disable iff (rst)
    (buf_en && !st_req && !ld_req) |-> !core_stall);  // R5
  AST_OFF_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!buf_en && ph_kind == PH_WRITE && !bus_ready) |-> core_stall);  // R6
  AST_SLOT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (slot_full && bus_ready) |=> !slot_full);  // R7
  AST_LOAD_WAITS: assert property (@(posedge clk) disable iff (rst)
    (ld_req && ph_kind != PH_READ) |-> core_stall);  // R8
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (ph_kind == PH_WRITE && !bus_ready) |=> ($stable(bus_wdata) && ph_kind == PH_WRITE));  // R9
endmodule

bind wr_post_buf wr_post_buf_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .buf_en     (buf_en),
  .st_req     (st_req),
  .ld_req     (ld_req),
  .core_stall (core_stall),
  .bus_avalid (bus_avalid),
  .bus_ready  (bus_ready),
  .bus_wdata  (bus_wdata),
  .ph_kind    (ph_kind),
  .slot_full  (slot_full)
);

// File: tb/wr_post_buf_tb.sv
`timescale 1ns/1ps
module wr_post_buf_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          buf_en = 1'b1;
  logic          st_req = 1'b0, ld_req = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [BW-1:0] st_be = '0;
  logic          core_stall;
  logic [DW-1:0] ld_rdata;
  logic          bus_avalid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [BW-1:0] bus_wbe;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_ready = 1'b0;

  wr_post_buf #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .buf_en(buf_en),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .ld_req(ld_req), .ld_addr(ld_addr),
    .core_stall(core_stall), .ld_rdata(ld_rdata),
    .bus_avalid(bus_avalid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wbe(bus_wbe),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  // program: kind 0 = no memory access, 1 = store, 2 = load
  int            q_kind[$];
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$];
  logic [BW-1:0] q_be[$];
  int            w_q[$];

  // reference slave / bus state
  bit            pend = 0, pend_wr = 0;
  int            pend_left = 0;
  logic [AW-1:0] pend_addr = '0;
  logic [DW-1:0] pend_data = '0;
  logic [BW-1:0] pend_be = '0;

  int n_chk = 0, n_fail = 0, stall_cnt = 0, hold_cnt = 0, cyc = 0;

  function automatic logic [DW-1:0] rd_pat(input logic [AW-1:0] a);
    return a ^ 32'hA5A5_0F0F;
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [DW-1:0] d, input logic [BW-1:0] be);
    logic [DW-1:0] r;
    for (int i = 0; i < BW; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int next_wait();
    if (w_q.size() > 0) return w_q.pop_front();
    return ($urandom_range(0, 9) == 0) ? 6 : int'($urandom_range(0, 3));
  endfunction

  task automatic push_op(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_be.push_back(be);
  endtask

  // one clock: entered and left just after a falling edge
  task automatic step();
    int k; bit have, own, ready_now, exp_stall, exp_issue;
    logic [AW-1:0] a; logic [DW-1:0] d; logic [BW-1:0] be;
    have = (q_kind.size() > 0);
    k  = have ? q_kind[0] : 0;
    a  = have ? q_addr[0] : '0;
    d  = have ? q_data[0] : '0;
    be = have ? q_be[0]   : '0;
    ready_now = pend && (pend_left == 0);
    st_req = (k == 1); ld_req = (k == 2);
    st_addr = a; ld_addr = a; st_data = d; st_be = be;
    bus_ready = ready_now;
    bus_rdata = (pend && !pend_wr) ? rd_pat(pend_addr) : '0;
    #1;
    own = (k == 2) && pend && !pend_wr;
    if (k == 1)      exp_stall = pend && !ready_now;
    else if (k == 2) exp_stall = own ? !ready_now : 1'b1;
    else             exp_stall = !buf_en && pend && pend_wr && !ready_now;
    exp_issue = ((k == 1) || (k == 2 && !own)) && (!pend || ready_now);

    if (k == 1)      chk("R4", "store stall", core_stall, exp_stall);
    else if (k == 2) chk("R8", "load stall", core_stall, exp_stall);
    else if (buf_en) chk("R5", "idle-cycle stall", core_stall, exp_stall);
    else             chk("R6", "idle-cycle stall", core_stall, exp_stall);
    chk("R1", "address phase valid", bus_avalid, exp_issue);
    if (exp_issue) begin
      chk("R9", "address phase write", bus_write, (k == 1));
      chk("R9", "address phase addr", bus_addr, a);
    end
    if (pend && pend_wr) begin
      chk("R10", "write data lanes", bus_wdata, lane_mask(pend_data, pend_be));
      chk("R2", "write byte enables", bus_wbe, pend_be);
    end
    if (own && ready_now) chk("R8", "load data", ld_rdata, rd_pat(a));

    if (exp_stall) begin stall_cnt++; hold_cnt++; end else hold_cnt = 0;
    @(posedge clk);
    cyc++;
    if (pend) begin
      if (ready_now) pend = 0; else pend_left--;
    end
    if (exp_issue) begin
      pend = 1; pend_wr = (k == 1); pend_left = next_wait();
      pend_addr = a; pend_data = d; pend_be = be;
    end
    if (have && !exp_stall) begin
      void'(q_kind.pop_front()); void'(q_addr.pop_front());
      void'(q_data.pop_front()); void'(q_be.pop_front());
    end
    @(negedge clk);
    if (hold_cnt > 64 || cyc > 150000) begin
      chk("R1", "watchdog", 1, 0);
      q_kind.delete(); q_addr.delete(); q_data.delete(); q_be.delete();
      hold_cnt = 0;
      pend = 0;
    end
  endtask

  task automatic run_all();
    while (q_kind.size() > 0) step();
    while (pend) step();
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R1", "reset: no address phase", bus_avalid, 0);
    chk("R5", "reset: no stall", core_stall, 0);
    rst = 1'b0;
    @(negedge clk);

    // R7: back-to-back stores, first waited 3 cycles
    buf_en = 1; w_q = '{3, 0}; stall_cnt = 0;
    push_op(1, 32'h100, 32'h1111_2222, 4'hF);
    push_op(1, 32'h104, 32'h3333_4444, 4'h5);
    run_all();
    chk("R7", "second store stall cycles", stall_cnt, 3);

    // R5: posted store, idle cycles slip past, then a load
    buf_en = 1; w_q = '{3, 0}; stall_cnt = 0;
    push_op(1, 32'h200, 32'hDEAD_BEEF, 4'hA);
    push_op(0, 0, 0, 0); push_op(0, 0, 0, 0); push_op(0, 0, 0, 0);
    push_op(2, 32'h208, 0, 0);
    run_all();
    chk("R5", "posted mode stall cycles", stall_cnt, 1);

    // R6: same program with posting off
    buf_en = 0; w_q = '{3, 0}; stall_cnt = 0;
    push_op(1, 32'h300, 32'hCAFE_F00D, 4'h3);
    push_op(0, 0, 0, 0); push_op(0, 0, 0, 0); push_op(0, 0, 0, 0);
    push_op(2, 32'h308, 0, 0);
    run_all();
    chk("R6", "blocking mode stall cycles", stall_cnt, 4);

    // R3: zero-wait stores leave the slot empty
    buf_en = 1; w_q = '{0, 0, 0}; stall_cnt = 0;
    push_op(1, 32'h400, 32'h0102_0304, 4'hF);
    push_op(1, 32'h404, 32'h0506_0708, 4'hC);
    push_op(2, 32'h408, 0, 0);
    run_all();
    chk("R3", "zero-wait stall cycles", stall_cnt, 1);

    // R8: lone load with two wait states
    buf_en = 1; w_q = '{2}; stall_cnt = 0;
    push_op(2, 32'h500, 0, 0);
    run_all();
    chk("R8", "lone load stall cycles", stall_cnt, 3);

    // random mixes in both modes
    for (int blk = 0; blk < 4; blk++) begin
      buf_en = blk[0];
      for (int i = 0; i < 600; i++)
        push_op(int'($urandom_range(0, 2)), {$urandom} & 32'hFFFF_FFFC, $urandom, 4'($urandom));
      run_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule